// File: doc/BRIEF.md
# Integer ALU with Trapping-Overflow Flag

This block is the execute-stage arithmetic and logic unit of a 32-bit load-store processor core. It is purely combinational. The pipeline hands it the primary opcode, the function code, the constant shift amount, both register operand values and the 16-bit immediate. In the same cycle it returns the result word and an overflow flag. The trap logic of the core uses that flag to raise an exception.

The block decodes the instruction class itself. For register-format instructions (opcode 0) it selects the operation from the function code, with the two register values as operands. For immediate-format instructions it widens the immediate. Logical operations use zero extension and arithmetic operations use sign extension. The widened immediate then replaces the second register operand.

The overflow flag is raised only by the trapping additions and subtractions. It is never raised by the non-trapping forms of those operations, which compute the same result bits.

Top module: `int_alu32`

## Requirements
- R1: With opcode 0, funct 32 (add) and 33 (addu) return rs+rt, and funct 34 (sub) and 35 (subu) return rs-rt, all wrapping modulo 2^32.
- R2: With opcode 0, funct 36, 37, 38 and 39 return rs AND rt, rs OR rt, rs XOR rt and NOT(rs OR rt).
- R3: The overflow output is 1 when a signed overflow occurs for funct 32 (add), funct 34 (sub) or opcode 8 (addi), and 0 otherwise. An add overflows when both operands have the same sign and the sum has the other sign. A subtract overflows when the operand signs differ and the result sign differs from rs.
- R4: The overflow output stays 0 for addu (33), subu (35), addiu (opcode 9), all logic, compare and shift operations, and lui, even when the signed result wraps.
- R5: Opcodes 12 (andi), 13 (ori) and 14 (xori) combine rs with the 16-bit immediate zero-extended to 32 bits.
- R6: Opcodes 8 (addi), 9 (addiu), 10 (slti) and 11 (sltiu) use the 16-bit immediate sign-extended to 32 bits.
- R7: funct 42 (slt) and opcode 10 (slti) return 1 when rs is less than the second operand as two's-complement numbers, and 0 otherwise.
- R8: funct 43 (sltu) and opcode 11 (sltiu) return 1 when rs is less than the second operand as unsigned numbers, and 0 otherwise.
- R9: funct 0 (sll), 2 (srl) and 3 (sra) shift rt by the 5-bit shamt input. sll and srl fill with zeros. sra fills with copies of rt bit 31.
- R10: funct 4 (sllv), 6 (srlv) and 7 (srav) shift rt by rs[4:0], with the same fill rules as R9. Bits 31:5 of rs have no effect.
- R11: Opcode 15 (lui) returns the immediate in bits 31:16 and zeros in bits 15:0. rs has no effect.
- R12: Any other opcode, and any funct not listed above under opcode 0, returns result 0 with overflow 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opcode | input | 6 | Primary opcode; 0 selects register format |
| funct | input | 6 | Function code, used only when opcode is 0 |
| shamt | input | 5 | Constant shift amount field |
| rs_val | input | 32 | First register operand; variable shift amount source |
| rt_val | input | 32 | Second register operand; value that shifts operate on |
| imm16 | input | 16 | Immediate field of immediate-format instructions |
| result | output | 32 | Operation result |
| overflow | output | 1 | Signed overflow of a trapping add or subtract |

## Verification
The bench drives each operand pair twice: once through a trapping opcode and once through its non-trapping twin. A design that decides overflow from the result alone would flag addu or addiu. One that tests only the add rule would miss 0x80000000 minus 1.

Immediates with bit 15 set go through both the logical and the arithmetic classes. Swapped extension shows up as garbage in bits 31:16. The compares use -1 against 1 and a small value against 0xFFFF, where signed and unsigned ordering disagree.

The shifts use a negative value under sra and srl. Variable shifts use rs values whose upper bits are set and whose low five bits are 0, which exposes a shifter that reads the whole register. Reserved codes must produce zero.

// File: rtl/int_alu_pkg.sv
package int_alu_pkg;

    localparam logic [5:0] OPC_REG   = 6'd0;
    localparam logic [5:0] OPC_ADDI  = 6'd8;
    localparam logic [5:0] OPC_ADDIU = 6'd9;
    localparam logic [5:0] OPC_SLTI  = 6'd10;
    localparam logic [5:0] OPC_SLTIU = 6'd11;
    localparam logic [5:0] OPC_ANDI  = 6'd12;
    localparam logic [5:0] OPC_ORI   = 6'd13;
    localparam logic [5:0] OPC_XORI  = 6'd14;
    localparam logic [5:0] OPC_LUI   = 6'd15;

    localparam logic [5:0] FN_SLL  = 6'd0;
    localparam logic [5:0] FN_SRL  = 6'd2;
    localparam logic [5:0] FN_SRA  = 6'd3;
    localparam logic [5:0] FN_SLLV = 6'd4;
    localparam logic [5:0] FN_SRLV = 6'd6;
    localparam logic [5:0] FN_SRAV = 6'd7;
    localparam logic [5:0] FN_ADD  = 6'd32;
    localparam logic [5:0] FN_ADDU = 6'd33;
    localparam logic [5:0] FN_SUB  = 6'd34;
    localparam logic [5:0] FN_SUBU = 6'd35;
    localparam logic [5:0] FN_AND  = 6'd36;
    localparam logic [5:0] FN_OR   = 6'd37;
    localparam logic [5:0] FN_XOR  = 6'd38;
    localparam logic [5:0] FN_NOR  = 6'd39;
    localparam logic [5:0] FN_SLT  = 6'd42;
    localparam logic [5:0] FN_SLTU = 6'd43;

    typedef enum logic [3:0] {
        K_ADD, K_SUB, K_AND, K_OR, K_XOR, K_NOR,
        K_SLT, K_SLTU, K_SHL, K_SHR, K_LUI, K_NONE
    } alu_kind_e;

    typedef enum logic { EXT_ZERO, EXT_SIGN } ext_e;

    typedef struct packed {
        alu_kind_e kind;
        logic      trap;     // overflow may be reported
        logic      use_imm;  // second operand from immediate
        ext_e      ext;      // immediate widening rule
        logic      var_amt;  // shift amount from rs
        logic      arith;    // right shift fills with sign
    } alu_ctl_t;

    localparam alu_ctl_t CTL_NONE = '{K_NONE, 1'b0, 1'b0, EXT_ZERO, 1'b0, 1'b0};

    function automatic alu_ctl_t ctl_reg(input alu_kind_e k, input logic tr,
                                         input logic va, input logic ar);
        alu_ctl_t c;
        c = CTL_NONE;
        c.kind = k; c.trap = tr; c.var_amt = va; c.arith = ar;
        return c;
    endfunction

    function automatic alu_ctl_t ctl_imm(input alu_kind_e k, input logic tr, input ext_e e);
        alu_ctl_t c;
        c = CTL_NONE;
        c.kind = k; c.trap = tr; c.use_imm = 1'b1; c.ext = e;
        return c;
    endfunction

    function automatic alu_ctl_t decode_insn(input logic [5:0] opc, input logic [5:0] fn);
        alu_ctl_t c;
        c = CTL_NONE;
        if (opc == OPC_REG) begin
            case (fn)
                FN_ADD:  c = ctl_reg(K_ADD,  1'b1, 1'b0, 1'b0);
                FN_ADDU: c = ctl_reg(K_ADD,  1'b0, 1'b0, 1'b0);
                FN_SUB:  c = ctl_reg(K_SUB,  1'b1, 1'b0, 1'b0);
                FN_SUBU: c = ctl_reg(K_SUB,  1'b0, 1'b0, 1'b0);
                FN_AND:  c = ctl_reg(K_AND,  1'b0, 1'b0, 1'b0);
                FN_OR:   c = ctl_reg(K_OR,   1'b0, 1'b0, 1'b0);
                FN_XOR:  c = ctl_reg(K_XOR,  1'b0, 1'b0, 1'b0);
                FN_NOR:  c = ctl_reg(K_NOR,  1'b0, 1'b0, 1'b0);
                FN_SLT:  c = ctl_reg(K_SLT,  1'b0, 1'b0, 1'b0);
                FN_SLTU: c = ctl_reg(K_SLTU, 1'b0, 1'b0, 1'b0);
                FN_SLL:  c = ctl_reg(K_SHL,  1'b0, 1'b0, 1'b0);
                FN_SRL:  c = ctl_reg(K_SHR,  1'b0, 1'b0, 1'b0);
                FN_SRA:  c = ctl_reg(K_SHR,  1'b0, 1'b0, 1'b1);
                FN_SLLV: c = ctl_reg(K_SHL,  1'b0, 1'b1, 1'b0);
                FN_SRLV: c = ctl_reg(K_SHR,  1'b0, 1'b1, 1'b0);
                FN_SRAV: c = ctl_reg(K_SHR,  1'b0, 1'b1, 1'b1);
                default: c = CTL_NONE;
            endcase
        end else begin
            case (opc)
                OPC_ADDI:  c = ctl_imm(K_ADD,  1'b1, EXT_SIGN);
                OPC_ADDIU: c = ctl_imm(K_ADD,  1'b0, EXT_SIGN);
                OPC_SLTI:  c = ctl_imm(K_SLT,  1'b0, EXT_SIGN);
                OPC_SLTIU: c = ctl_imm(K_SLTU, 1'b0, EXT_SIGN);
                OPC_ANDI:  c = ctl_imm(K_AND,  1'b0, EXT_ZERO);
                OPC_ORI:   c = ctl_imm(K_OR,   1'b0, EXT_ZERO);
                OPC_XORI:  c = ctl_imm(K_XOR,  1'b0, EXT_ZERO);
                OPC_LUI:   c = ctl_imm(K_LUI,  1'b0, EXT_ZERO);
                default:   c = CTL_NONE;
            endcase
        end
        return c;
    endfunction

endpackage

// File: rtl/int_alu_decode.sv
module int_alu_decode
    import int_alu_pkg::*;
(
    input  logic [5:0] opcode,
    input  logic [5:0] funct,
    output alu_ctl_t   ctl
);
    always_comb ctl = decode_insn(opcode, funct);
endmodule

// File: rtl/int_alu_operands.sv
module int_alu_operands
    import int_alu_pkg::*;
#(
    parameter int XLEN = 32,
    parameter int IMMW = 16,
    localparam int SHW = $clog2(XLEN)
) (
    input  logic            use_imm,
    input  ext_e            ext,
    input  logic            var_amt,
    input  logic [SHW-1:0]  shamt,
    input  logic [XLEN-1:0] rs_val,
    input  logic [XLEN-1:0] rt_val,
    input  logic [IMMW-1:0] imm,
    output logic [XLEN-1:0] opnd_a,
    output logic [XLEN-1:0] opnd_b,
    output logic [SHW-1:0]  amt
);
    localparam int PADW = XLEN - IMMW;

    logic [XLEN-1:0] imm_wide;

    always_comb begin
        if (ext == EXT_SIGN) imm_wide = {{PADW{imm[IMMW-1]}}, imm};
        else                 imm_wide = {{PADW{1'b0}}, imm};
        opnd_a = rs_val;
        opnd_b = use_imm ? imm_wide : rt_val;
        amt    = var_amt ? rs_val[SHW-1:0] : shamt;
    end
endmodule

// File: rtl/int_alu_core.sv
module int_alu_core
    import int_alu_pkg::*;
#(
    parameter int XLEN = 32,
    parameter int IMMW = 16,
    localparam int SHW = $clog2(XLEN),
    localparam int MSB = XLEN - 1
) (
    input  alu_kind_e       kind,
    input  logic            trap,
    input  logic            arith,
    input  logic [XLEN-1:0] a,
    input  logic [XLEN-1:0] b,
    input  logic [SHW-1:0]  amt,
    output logic [XLEN-1:0] res,
    output logic            ovf
);
    logic [XLEN-1:0] sum, diff;
    logic            lt_s, lt_u, fill, go_left;
    logic [XLEN-1:0] b_rev, sh_in, sh_rev;
    logic [XLEN-1:0] stage [SHW+1];

    assign sum     = a + b;
    assign diff    = a - b;
    assign lt_s    = $signed(a) < $signed(b);
    assign lt_u    = a < b;
    assign go_left = (kind == K_SHL);
    assign fill    = arith & b[MSB] & ~go_left;

    // one right-shifting barrel; left shifts run through it bit-reversed
    for (genvar i = 0; i < XLEN; i++) begin : g_rev
        assign b_rev[i]  = b[MSB-i];
        assign sh_rev[i] = stage[SHW][MSB-i];
    end

    assign sh_in    = go_left ? b_rev : b;
    assign stage[0] = sh_in;

    for (genvar s = 0; s < SHW; s++) begin : g_stage
        localparam int D = 1 << s;
        assign stage[s+1] = amt[s] ? {{D{fill}}, stage[s][MSB:D]} : stage[s];
    end

    always_comb begin
        res = '0;
        ovf = 1'b0;
        case (kind)
            K_ADD: begin
                res = sum;
                ovf = trap & (a[MSB] == b[MSB]) & (sum[MSB] != a[MSB]);
            end
            K_SUB: begin
                res = diff;
                ovf = trap & (a[MSB] != b[MSB]) & (diff[MSB] != a[MSB]);
            end
            K_AND:  res = a & b;
            K_OR:   res = a | b;
            K_XOR:  res = a ^ b;
            K_NOR:  res = ~(a | b);
            K_SLT:  res = {{(XLEN-1){1'b0}}, lt_s};
            K_SLTU: res = {{(XLEN-1){1'b0}}, lt_u};
            K_SHL:  res = sh_rev;
            K_SHR:  res = stage[SHW];
            K_LUI:  res = b << IMMW;
            default: res = '0;
        endcase
    end
endmodule

// File: rtl/int_alu32.sv
module int_alu32
    import int_alu_pkg::*;
#(
    parameter int XLEN = 32,
    parameter int IMMW = 16,
    localparam int SHW = $clog2(XLEN)
) (
    input  logic [5:0]      opcode,
    input  logic [5:0]      funct,
    input  logic [SHW-1:0]  shamt,
    input  logic [XLEN-1:0] rs_val,
    input  logic [XLEN-1:0] rt_val,
    input  logic [IMMW-1:0] imm16,
    output logic [XLEN-1:0] result,
    output logic            overflow
);
    alu_ctl_t        ctl;
    logic [XLEN-1:0] opnd_a, opnd_b;
    logic [SHW-1:0]  amt;

    int_alu_decode u_dec (
        .opcode (opcode),
        .funct  (funct),
        .ctl    (ctl)
    );

    int_alu_operands #(.XLEN(XLEN), .IMMW(IMMW)) u_opnd (
        .use_imm (ctl.use_imm),
        .ext     (ctl.ext),
        .var_amt (ctl.var_amt),
        .shamt   (shamt),
        .rs_val  (rs_val),
        .rt_val  (rt_val),
        .imm     (imm16),
        .opnd_a  (opnd_a),
        .opnd_b  (opnd_b),
        .amt     (amt)
    );

    int_alu_core #(.XLEN(XLEN), .IMMW(IMMW)) u_core (
        .kind  (ctl.kind),
        .trap  (ctl.trap),
        .arith (ctl.arith),
        .a     (opnd_a),
        .b     (opnd_b),
        .amt   (amt),
        .res   (result),
        .ovf   (overflow)
    );
endmodule

// File: rtl/int_alu32_chk.sv
module int_alu32_chk
    import int_alu_pkg::*;
#(
    parameter int XLEN = 32,
    parameter int IMMW = 16
) (
    input logic [5:0]      opcode,
    input logic [5:0]      funct,
    input logic [XLEN-1:0] result,
    input logic            overflow
);
    logic is_reg, trapping, cmp_op, known_opc;

    always_comb begin
        is_reg    = (opcode == OPC_REG);
        trapping  = (opcode == OPC_ADDI) || (is_reg && (funct == FN_ADD || funct == FN_SUB));
        cmp_op    = (opcode == OPC_SLTI) || (opcode == OPC_SLTIU) ||
                    (is_reg && (funct == FN_SLT || funct == FN_SLTU));
        known_opc = is_reg || (opcode >= OPC_ADDI && opcode <= OPC_LUI);

        // R4: only trapping forms may report overflow
        a_r4_no_overflow: assert (!overflow || trapping)
            else $error("overflow from non-trapping operation");
        // R7, R8: compares yield a single-bit truth value
        a_r7_cmp_boolean: assert (!cmp_op || result[XLEN-1:1] == '0)
            else $error("compare result wider than one bit");
        // R11: lower half of lui result is zero
        a_r11_lui_low_zero: assert (opcode != OPC_LUI || result[IMMW-1:0] == '0)
            else $error("lui low half not zero");
        // R5: andi cannot set bits above the immediate
        a_r5_andi_upper_zero: assert (opcode != OPC_ANDI || result[XLEN-1:IMMW] == '0)
            else $error("andi upper half not zero");
        // R12: reserved opcodes stay quiet
        a_r12_unknown_quiet: assert (known_opc || (result == '0 && !overflow))
            else $error("reserved opcode produced output");
    end
endmodule

bind int_alu32 int_alu32_chk #(.XLEN(XLEN), .IMMW(IMMW)) u_chk (
    .opcode   (opcode),
    .funct    (funct),
    .result   (result),
    .overflow (overflow)
);

// File: tb/tb_int_alu32.sv
module tb_int_alu32;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic [5:0]  opcode = '0;
    logic [5:0]  funct = '0;
    logic [4:0]  shamt = '0;
    logic [31:0] rs_val = '0;
    logic [31:0] rt_val = '0;
    logic [15:0] imm16 = '0;
    logic [31:0] result;
    logic        overflow;

    int n_checks = 0;
    int n_fail   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    int_alu32 dut (
        .opcode (opcode), .funct (funct), .shamt (shamt),
        .rs_val (rs_val), .rt_val (rt_val), .imm16 (imm16),
        .result (result), .overflow (overflow)
    );

    function automatic logic [31:0] sx(input logic [15:0] v);
        return {{16{v[15]}}, v};
    endfunction

    function automatic logic [31:0] zx(input logic [15:0] v);
        return {16'h0, v};
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic run_r(input logic [5:0] fn, input logic [31:0] a, input logic [31:0] b,
                         input logic [4:0] sh);
        @(negedge clk);
        opcode = 6'd0; funct = fn; rs_val = a; rt_val = b; shamt = sh; imm16 = 16'hA5A5;
        #(CLK_PERIOD/4);
    endtask

    task automatic run_i(input logic [5:0] opc, input logic [31:0] a, input logic [15:0] im);
        @(negedge clk);
        opcode = opc; funct = 6'd32; rs_val = a; rt_val = 32'h5A5A_5A5A; shamt = 5'd7; imm16 = im;
        #(CLK_PERIOD/4);
    endtask

    task automatic t_idle();
        run_r(6'd0, 32'h0, 32'h0, 5'd0);
        check("R9 idle result", result, 32'h0);
        check("R4 idle overflow", {31'h0, overflow}, 32'h0);
    endtask

    task automatic t_add_sub();
        run_r(6'd32, 32'h1234_5678, 32'h1111_1111, 5'd0);
        check("R1 add", result, 32'h2345_6789);
        run_r(6'd33, 32'hFFFF_FFFF, 32'h0000_0002, 5'd0);
        check("R1 addu wrap", result, 32'h0000_0001);
        run_r(6'd34, 32'h0000_0005, 32'h0000_0007, 5'd0);
        check("R1 sub", result, 32'hFFFF_FFFE);
        run_r(6'd35, 32'h8000_0000, 32'h0000_0001, 5'd0);
        check("R1 subu", result, 32'h7FFF_FFFF);
    endtask

    task automatic t_logic();
        run_r(6'd36, 32'hF0F0_FF00, 32'hFF00_0FF0, 5'd0);
        check("R2 and", result, 32'hF000_0F00);
        run_r(6'd37, 32'hF0F0_FF00, 32'hFF00_0FF0, 5'd0);
        check("R2 or", result, 32'hFFF0_FFF0);
        run_r(6'd38, 32'hF0F0_FF00, 32'hFF00_0FF0, 5'd0);
        check("R2 xor", result, 32'h0FF0_F0F0);
        run_r(6'd39, 32'hF0F0_FF00, 32'hFF00_0FF0, 5'd0);
        check("R2 nor", result, 32'h000F_000F);
    endtask

    task automatic t_overflow();
        run_r(6'd32, 32'h7FFF_FFFF, 32'h1, 5'd0);
        check("R3 add ovf flag", {31'h0, overflow}, 32'h1);
        check("R3 add ovf result", result, 32'h8000_0000);
        run_r(6'd32, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 5'd0);
        check("R3 add neg no ovf", {31'h0, overflow}, 32'h0);
        run_r(6'd34, 32'h8000_0000, 32'h1, 5'd0);
        check("R3 sub ovf flag", {31'h0, overflow}, 32'h1);
        run_r(6'd34, 32'h0000_0000, 32'h8000_0000, 5'd0);
        check("R3 sub 0-min ovf", {31'h0, overflow}, 32'h1);
        run_r(6'd34, 32'hFFFF_FFFF, 32'h8000_0000, 5'd0);
        check("R3 sub no ovf", {31'h0, overflow}, 32'h0);
        run_i(6'd8, 32'h7FFF_FFF0, 16'h0010);
        check("R3 addi ovf flag", {31'h0, overflow}, 32'h1);
    endtask

    task automatic t_no_overflow();
        run_r(6'd33, 32'h7FFF_FFFF, 32'h1, 5'd0);
        check("R4 addu no ovf", {31'h0, overflow}, 32'h0);
        check("R4 addu result", result, 32'h8000_0000);
        run_r(6'd35, 32'h8000_0000, 32'h1, 5'd0);
        check("R4 subu no ovf", {31'h0, overflow}, 32'h0);
        run_i(6'd9, 32'h7FFF_FFF0, 16'h0010);
        check("R4 addiu no ovf", {31'h0, overflow}, 32'h0);
        check("R4 addiu result", result, 32'h8000_0000);
        run_r(6'd42, 32'h7FFF_FFFF, 32'h8000_0000, 5'd0);
        check("R4 slt no ovf", {31'h0, overflow}, 32'h0);
    endtask

    task automatic t_imm_ext();
        run_i(6'd12, 32'hFFFF_FFFF, 16'h8001);
        check("R5 andi zext", result, 32'hFFFF_FFFF & zx(16'h8001));
        run_i(6'd13, 32'h0000_0000, 16'h8000);
        check("R5 ori zext", result, zx(16'h8000));
        run_i(6'd14, 32'hFFFF_0000, 16'hFFFF);
        check("R5 xori zext", result, 32'hFFFF_0000 ^ zx(16'hFFFF));
        run_i(6'd8, 32'd5, 16'hFFFF);
        check("R6 addi sext", result, 32'd5 + sx(16'hFFFF));
        run_i(6'd9, 32'd0, 16'h8000);
        check("R6 addiu sext", result, sx(16'h8000));
    endtask

    task automatic t_compare();
        run_r(6'd42, 32'hFFFF_FFFF, 32'h1, 5'd0);
        check("R7 slt signed", result, 32'h1);
        run_r(6'd42, 32'h5, 32'h5, 5'd0);
        check("R7 slt equal", result, 32'h0);
        run_i(6'd10, 32'hFFFF_FFFE, 16'hFFFF);
        check("R7 slti", result, 32'h1);
        run_r(6'd43, 32'hFFFF_FFFF, 32'h1, 5'd0);
        check("R8 sltu", result, 32'h0);
        run_i(6'd11, 32'd5, 16'hFFFF);
        check("R8 sltiu sext unsigned", result, 32'h1);
    endtask

    task automatic t_shift_const();
        run_r(6'd0, 32'hFFFF_FFFF, 32'h1, 5'd31);
        check("R9 sll", result, 32'h8000_0000);
        run_r(6'd2, 32'h0, 32'h8000_0000, 5'd4);
        check("R9 srl", result, 32'h0800_0000);
        run_r(6'd3, 32'h0, 32'h8000_0000, 5'd4);
        check("R9 sra neg", result, 32'hF800_0000);
        run_r(6'd3, 32'h0, 32'h4000_0000, 5'd30);
        check("R9 sra pos", result, 32'h1);
    endtask

    task automatic t_shift_var();
        run_r(6'd4, 32'hFFFF_FFE3, 32'h1, 5'd17);
        check("R10 sllv", result, 32'h8);
        run_r(6'd7, 32'd33, 32'h8000_0000, 5'd0);
        check("R10 srav", result, 32'hC000_0000);
        run_r(6'd6, 32'hFFFF_FFE0, 32'h8765_4321, 5'd9);
        check("R10 srlv upper ignored", result, 32'h8765_4321);
        run_r(6'd6, 32'd4, 32'hF000_0000, 5'd0);
        check("R10 srlv", result, 32'h0F00_0000);
    endtask

    task automatic t_lui();
        run_i(6'd15, 32'hDEAD_BEEF, 16'h1234);
        check("R11 lui", result, 32'h1234_0000);
        run_i(6'd15, 32'h0, 16'hFFFF);
        check("R11 lui high", result, 32'hFFFF_0000);
    endtask

    task automatic t_unknown();
        run_i(6'd63, 32'hFFFF_FFFF, 16'hFFFF);
        check("R12 opcode result", result, 32'h0);
        check("R12 opcode ovf", {31'h0, overflow}, 32'h0);
        run_r(6'd1, 32'h7FFF_FFFF, 32'h1, 5'd3);
        check("R12 funct result", result, 32'h0);
        run_r(6'd44, 32'h7FFF_FFFF, 32'h7FFF_FFFF, 5'd3);
        check("R12 funct ovf", {31'h0, overflow}, 32'h0);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

    initial begin
        t_idle();
        t_add_sub();
        t_logic();
        t_overflow();
        t_no_overflow();
        t_imm_ext();
        t_compare();
        t_shift_const();
        t_shift_var();
        t_lui();
        t_unknown();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end
endmodule